// File: doc/BRIEF.md
# Digital Frequency Trim Prescaler

This block divides a crystal-derived oscillator clock, nominally 32768 Hz, down to a one-cycle tick once per second. It also applies a digital rate correction. A 6-bit trim code sets a signed adjustment. The block carries out that adjustment by changing how many oscillator cycles make up a second. It never touches the oscillator itself.

Corrections are spread over a correction window of `WIN` seconds (15 by default). At that window length one oscillator count per window is close to 2 ppm. The two signs are asymmetric:

- A negative code lengthens the window by N cycles, which slows the tick.
- A positive code shortens the window by 2·N cycles, which speeds the tick up.

The positive range is therefore twice the negative range. Software writes the code through a simple write strobe and can read it back at any time. A new code is picked up only when the next window begins, so the adjustment already running is never disturbed.

Top module: `trim_prescaler`

## Requirements
- R1: `trim_rd` returns the stored code in bits 5:0, and bits 7:6 always read 0. After reset it reads 0x00.
- R2: When `wr_en` is high at a clock edge, `wr_data[5:0]` is stored on that edge and appears on `trim_rd` in the following cycle. `wr_data[7:6]` is discarded.
- R3: Bit 5 of the code is the sign and bits 4:0 are the magnitude N (0 to 31).
- R4: `tick` is high for exactly one cycle: the last oscillator cycle of each second. With no active correction, a second is `DIV` cycles long.
- R5: With sign 0, a full window lasts `WIN*DIV + N` cycles.
- R6: With sign 1, a full window lasts `WIN*DIV - 2*N` cycles.
- R7: With N = 0, every second is exactly `DIV` cycles, whatever the sign bit.
- R8: No single second differs from `DIV` by more than STEP_MAX = ceil(62 / `WIN`) cycles (5 by default). Seconds with a correction all go in the same direction.
- R9: The code used for a window is the one stored when the previous window ended. A write issued in the final cycle of a window applies one window later. A write never changes the length of the window in progress, and if several writes fall in one window the last one wins.
- R10: Synchronous active-high `rst` clears the code, the cycle counter and the window state, and holds `tick` low. The first window after reset is nominal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the trim code |
| wr_data | input | 8 | Write data; bits 5:0 are stored |
| trim_rd | output | 8 | Readback of the trim code, with bits 7:6 as zero |
| tick | output | 1 | One-cycle pulse ending each second |

## Verification
Two events can land on the same edge: the window reload, which latches the code for the coming window, and a register write. The bench provokes this by raising `wr_en` in exactly the cycle where it sees the window's fifteenth `tick`. It then expects the old code to govern the next window and the new code the window after. A scoreboard compares every measured window length against the value computed from R5 to R7. It also bounds every single second against R8.

// File: rtl/trim_pkg.sv
package trim_pkg;

    localparam int MAG_BITS = 5;
    localparam int MAG_MAX  = (1 << MAG_BITS) - 1;
    localparam int POS_GAIN = 2;
    localparam int ADJ_W    = MAG_BITS + 2;

    typedef struct packed {
        logic                sign;
        logic [MAG_BITS-1:0] mag;
    } trim_t;

    // Cycles added (sign 0) or removed (sign 1) over one window.
    function automatic logic [ADJ_W-1:0] window_adjust(trim_t t);
        logic [ADJ_W-1:0] m;
        m = ADJ_W'(t.mag);
        return t.sign ? ADJ_W'(m * POS_GAIN) : m;
    endfunction

    // Largest per-second step that still drains the biggest adjustment in one window.
    function automatic int step_limit(int win_sec);
        return (POS_GAIN * MAG_MAX + win_sec - 1) / win_sec;
    endfunction

endpackage

// File: rtl/trim_reg.sv
module trim_reg
    import trim_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output trim_t      trim,
    output logic [7:0] rd
);

    always_ff @(posedge clk) begin
        if (rst)
            trim <= '0;
        else if (wr_en)
            trim <= trim_t'(wr_data[5:0]);
    end

    assign rd = {2'b00, trim};

endmodule

// File: rtl/trim_window.sv
module trim_window
    import trim_pkg::*;
#(
    parameter int WIN      = 15,
    parameter int STEP_MAX = 5,
    parameter int STEP_W   = 3,
    parameter int SEC_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  trim_t             trim,
    output logic [STEP_W-1:0] step,
    output logic              shorten,
    output logic [SEC_W-1:0]  sec_idx,
    output logic [ADJ_W-1:0]  pending
);

    localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(WIN - 1);
    localparam logic [ADJ_W-1:0] CAP      = ADJ_W'(STEP_MAX);

    logic last_sec;

    assign last_sec = (sec_idx == LAST_SEC);
    assign step     = (pending > CAP) ? STEP_W'(CAP) : STEP_W'(pending);

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_idx <= '0;
            pending <= '0;
            shorten <= 1'b0;
        end else if (tick) begin
            if (last_sec) begin
                sec_idx <= '0;
                pending <= window_adjust(trim);
                shorten <= trim.sign;
            end else begin
                sec_idx <= sec_idx + 1'b1;
                pending <= pending - ADJ_W'(step);
            end
        end
    end

endmodule

// File: rtl/trim_second.sv
module trim_second #(
    parameter int DIV    = 32768,
    parameter int STEP_W = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STEP_W-1:0] step,
    input  logic              shorten,
    output logic              tick
);

    localparam logic [CNT_W-1:0] NOM_LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last = shorten ? (NOM_LAST - CNT_W'(step)) : (NOM_LAST + CNT_W'(step));
    assign tick = !rst && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/trim_prescaler.sv
module trim_prescaler
    import trim_pkg::*;
#(
    parameter int DIV = 32768,
    parameter int WIN = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] trim_rd,
    output logic       tick
);

    localparam int STEP_MAX = step_limit(WIN);
    localparam int STEP_W   = $clog2(STEP_MAX + 1);
    localparam int SEC_W    = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int CNT_W    = $clog2(DIV + STEP_MAX + 1);

    trim_t             trim;
    logic [STEP_W-1:0] step;
    logic              shorten;
    logic [SEC_W-1:0]  sec_idx;
    logic [ADJ_W-1:0]  pending;

    trim_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .trim    (trim),
        .rd      (trim_rd)
    );

    trim_window #(
        .WIN      (WIN),
        .STEP_MAX (STEP_MAX),
        .STEP_W   (STEP_W),
        .SEC_W    (SEC_W)
    ) u_win (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .trim    (trim),
        .step    (step),
        .shorten (shorten),
        .sec_idx (sec_idx),
        .pending (pending)
    );

    trim_second #(
        .DIV    (DIV),
        .STEP_W (STEP_W),
        .CNT_W  (CNT_W)
    ) u_sec (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .shorten (shorten),
        .tick    (tick)
    );

endmodule

// File: rtl/trim_prescaler_chk.sv
module trim_prescaler_chk #(
    parameter int WIN      = 15,
    parameter int STEP_MAX = 5,
    parameter int STEP_W   = 3,
    parameter int SEC_W    = 4,
    parameter int ADJ_W    = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic [7:0]        trim_rd,
    input logic              tick,
    input logic [SEC_W-1:0]  sec_idx,
    input logic [ADJ_W-1:0]  pending,
    input logic [STEP_W-1:0] step
);

    // R1: upper readback bits stay zero
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
        trim_rd[7:6] == 2'b00);

    // R2: a write is visible on the readback one cycle later
    a_r2_write_visible: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> trim_rd == {2'b00, $past(wr_data[5:0])});

    // R4: tick never lasts two cycles
    a_r4_single_tick: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R8: the applied step never exceeds the limit
    a_r8_step_cap: assert property (@(posedge clk) disable iff (rst)
        32'(step) <= STEP_MAX);

    // R9: the window state moves only on a tick
    a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(sec_idx) && $stable(pending));

    // R5/R6: the adjustment is drained by the end of each window
    a_r5_window_drained: assert property (@(posedge clk) disable iff (rst)
        (tick && 32'(sec_idx) == WIN - 1) |-> 32'(pending) <= STEP_MAX);

    // R7: a zero magnitude leaves nothing pending for the next window
    a_r7_zero_mag: assert property (@(posedge clk) disable iff (rst)
        (tick && 32'(sec_idx) == WIN - 1 && trim_rd[4:0] == 5'd0) |=> pending == '0);

endmodule

bind trim_prescaler trim_prescaler_chk #(
    .WIN      (WIN),
    .STEP_MAX (STEP_MAX),
    .STEP_W   (STEP_W),
    .SEC_W    (SEC_W),
    .ADJ_W    (trim_pkg::ADJ_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .trim_rd (trim_rd),
    .tick    (tick),
    .sec_idx (sec_idx),
    .pending (pending),
    .step    (step)
);

// File: tb/trim_prescaler_test.sv
module trim_prescaler_test;

    localparam int DIV  = 64;
    localparam int WIN  = 15;
    localparam int NOM  = DIV * WIN;
    localparam int SMAX = (62 + WIN - 1) / WIN;
    localparam int NWIN = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] trim_rd;
    logic       tick;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string req_q[$];
    int sec_len = 0;
    int win_len = 0;
    int sec_in_win = 0;
    int windows_done = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    trim_prescaler #(.DIV(DIV), .WIN(WIN)) uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .trim_rd (trim_rd),
        .tick    (tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected window length from R5/R6/R7
    function automatic int win_expect(input logic [7:0] code);
        int n;
        n = int'(code[4:0]);
        return code[5] ? NOM - 2 * n : NOM + n;
    endfunction

    task automatic push(input int total, input string req);
        exp_q.push_back(total);
        req_q.push_back(req);
    endtask

    task automatic write_trim(input logic [7:0] code);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = code;
        @(negedge clk);
        wr_en = 1'b0;
        check(trim_rd == {2'b00, code[5:0]}, "R2 readback", int'(trim_rd), int'({2'b00, code[5:0]}));
    endtask

    task automatic wait_mid(input int win_idx);
        while (!(windows_done == win_idx && sec_in_win == 7)) @(posedge clk);
    endtask

    // monitor: measures seconds and windows, compares with the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            sec_len++;
            win_len++;
            if (tick) begin
                check(sec_len >= DIV - SMAX && sec_len <= DIV + SMAX, "R8 second bound", sec_len, DIV);
                if (exp_q.size() > 0 && exp_q[0] == NOM)
                    check(sec_len == DIV, "R7 nominal second", sec_len, DIV);
                sec_len = 0;
                sec_in_win++;
                if (sec_in_win == WIN) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9 scoreboard empty", win_len, 0);
                    end else begin
                        int e;
                        string r;
                        e = exp_q.pop_front();
                        r = req_q.pop_front();
                        check(win_len == e, r, win_len, e);
                    end
                    win_len = 0;
                    sec_in_win = 0;
                    windows_done++;
                end
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(tick == 1'b0, "R10 tick low after reset", int'(tick), 0);
        check(trim_rd == 8'h00, "R1 reset readback", int'(trim_rd), 0);
        push(NOM, "R10 first window nominal");

        wait_mid(0);
        write_trim(8'h05);
        push(win_expect(8'h05), "R5 sign0 mag5");

        wait_mid(1);
        write_trim(8'h25);
        push(win_expect(8'h25), "R6 sign1 mag5");

        wait_mid(2);
        write_trim(8'h3F);
        push(win_expect(8'h3F), "R6 sign1 mag31");

        wait_mid(3);
        write_trim(8'h1F);
        push(win_expect(8'h1F), "R5 sign0 mag31");

        wait_mid(4);
        write_trim(8'h20);
        push(NOM, "R7 sign1 mag0");

        wait_mid(5);
        write_trim(8'h0A);
        write_trim(8'h21);
        push(win_expect(8'h21), "R9 last write wins");

        // R9: write in the reload cycle of window 7
        while (!(windows_done == 6 && sec_in_win == WIN - 1)) @(posedge clk);
        @(negedge clk);
        while (!tick) @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'h03;
        @(negedge clk);
        wr_en = 1'b0;
        check(trim_rd == 8'h03, "R2 boundary readback", int'(trim_rd), 3);
        push(win_expect(8'h21), "R9 boundary write deferred");
        push(win_expect(8'h03), "R9 boundary write applied");

        wait_mid(8);
        write_trim(8'hC4);
        check(trim_rd == 8'h04, "R1 upper bits dropped", int'(trim_rd), 4);
        push(win_expect(8'h04), "R3 field decode");

        while (windows_done < NWIN) @(posedge clk);
        check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog windows=%0d expected=%0d", windows_done, NWIN);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule